// File: doc/BRIEF.md
# Disk Controller Host Phase Sequencer

This block is the host-facing side of a two-drive floppy-style disk controller. The host sees two things. One is a read-only status byte. The other is a byte-wide data port, which it writes during the command phase and reads during the execution and result phases. The sequencer collects command bytes and decodes the opcode from the first byte. It may start a seek on either drive. It runs an execution phase, either paced by the host (polled) or handed to an external DMA engine. It then presents result bytes until the host has read them all.

Seek and recalibrate commands free the host as soon as their last byte arrives. The drive's busy flag stays up until a per-drive step-done pulse arrives, and that pulse leaves an interrupt status pending. A later sense-interrupt command collects that status. Both drives can seek at the same time. A read to a cylinder other than the drive's present cylinder first performs an implied seek.

Top module: `fdc_phase_seq`

## Requirements
- R1: After synchronous reset, status reads 0x80, proto_err is 0 and dma_req is 0. Whenever command busy (status bit 4) is 0, RQM is 1 and DIO is 0.
- R2: Status bit fields: 7 RQM, 6 DIO, 5 polled-execution, 4 command busy, 3..2 always 0, 1 drive-1 busy, 0 drive-0 busy. The status byte changes in the cycle after a data access.
- R3: The opcode is the low five bits of the first byte: 0x03 specify (3 bytes), 0x0F seek (3 bytes), 0x07 recalibrate (2 bytes), 0x08 sense-interrupt (1 byte), 0x06 read-data (9 bytes). Command busy is 1 from the first accepted byte until the last result byte is read.
- R4: Seek (byte 1 bit 0 drive, byte 2 cylinder) and recalibrate (byte 1 bit 0 drive, cylinder 0) clear command busy right after their last byte. They set the drive's busy bit until step_done for that drive. Both drives may seek at once.
- R5: Sense-interrupt returns two bytes, 0x20 OR drive and then the present cylinder, for the lowest-numbered drive with pending status, and clears that drive's pending status. With nothing pending it returns the single byte 0x80.
- R6: Read-data: byte 1 bit 0 is the drive and bytes 2..5 are cylinder, head, sector and size. If the cylinder differs from the drive's present cylinder, an implied seek runs first. During it, RQM is 0 and the drive busy bit is 1 until step_done.
- R7: In polled mode the execution phase shows RQM=1, DIO=1 and bit 5 set. It offers EXEC_BYTES bytes whose values are 0, 1, 2 and so on. RQM drops for one cycle after each byte is read.
- R8: In DMA mode the execution phase holds dma_req at 1, RQM at 0 and bit 5 at 0. Each dma_ack counts one byte, up to EXEC_BYTES.
- R9: The read-data result bytes are: drive, 0, 0, cylinder, head, sector, size.
- R10: A write while RQM=0 or DIO=1, or a read while RQM=0 or DIO=0, is ignored and sets proto_err, which stays set until reset.
- R11: Specify byte 2 bit 0 selects polled (1) or DMA (0) mode, and reset selects DMA. Any opcode not listed in R3 is one byte long and returns the single result byte 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host data-port write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host data-port read strobe |
| rd_data | output | 8 | Byte currently offered to the host |
| status | output | 8 | Main status byte |
| step_done | input | 2 | Per-drive seek completion pulse |
| dma_req | output | 1 | DMA execution request |
| dma_ack | input | 1 | DMA byte acknowledge |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Every result of an access or a step_done pulse appears one clock after the edge that samples it. This covers status, the offered byte, proto_err and the drive busy bits. The exception is the end of an implied seek, which reaches the execution phase one clock later because the phase register sees the busy bit drop first. The bench drives inputs on the falling edge and samples on the following falling edge. This places every check exactly one register stage after its stimulus, and the one extra wait after an implied seek is explicit. Seeks, sense-interrupts and reads with random cylinders, drives and sector fields are compared with a bench-side model of present cylinders and pending status.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_SEEK, PH_EXEC, PH_RES} phase_e;

  localparam logic [4:0] OP_SPECIFY = 5'h03;
  localparam logic [4:0] OP_SEEK    = 5'h0F;
  localparam logic [4:0] OP_RECAL   = 5'h07;
  localparam logic [4:0] OP_SENSE   = 5'h08;
  localparam logic [4:0] OP_READ    = 5'h06;

  localparam logic [7:0] ST0_INVALID  = 8'h80;
  localparam logic [7:0] ST0_SEEK_END = 8'h20;

  localparam int CMD_MAX = 9;
  localparam int RES_MAX = 7;

  // Number of command bytes for an opcode
  function automatic logic [3:0] cmd_len(input logic [4:0] op);
    case (op)
      OP_SPECIFY, OP_SEEK: return 4'd3;
      OP_RECAL:            return 4'd2;
      OP_READ:             return 4'd9;
      default:             return 4'd1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic rqm, input logic dio,
                                             input logic ndma, input logic cb,
                                             input logic [1:0] drv_busy);
    return {rqm, dio, ndma, cb, 2'b00, drv_busy};
  endfunction
endpackage

// File: rtl/fdc_drive_track.sv
module fdc_drive_track #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          explicit_seek,
  input  logic [CW-1:0] target,
  input  logic          step_done,
  input  logic          clr_pend,
  output logic          busy,
  output logic [CW-1:0] pcn,
  output logic          pending
);
  logic [CW-1:0] tgt_q;
  logic          expl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pcn     <= '0;
      pending <= 1'b0;
      tgt_q   <= '0;
      expl_q  <= 1'b0;
    end else begin
      if (clr_pend) pending <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        tgt_q  <= target;
        expl_q <= explicit_seek;
      end else if (busy && step_done) begin
        busy <= 1'b0;
        pcn  <= tgt_q;
        if (expl_q) pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdc_status_gen.sv
module fdc_status_gen
  import fdc_pkg::*;
(
  input  phase_e     phase,
  input  logic       mid_cmd,
  input  logic       gap,
  input  logic       nd_mode,
  input  logic [1:0] drv_busy,
  output logic       rqm,
  output logic       dio,
  output logic       dma_req,
  output logic [7:0] status
);
  logic ndma, cb;

  always_comb begin
    rqm     = 1'b0;
    dio     = 1'b0;
    ndma    = 1'b0;
    dma_req = 1'b0;
    case (phase)
      PH_CMD:  rqm = 1'b1;
      PH_SEEK: rqm = 1'b0;
      PH_EXEC: begin
        rqm     = nd_mode && !gap;
        dio     = nd_mode;
        ndma    = nd_mode;
        dma_req = !nd_mode;
      end
      default: begin
        rqm = 1'b1;
        dio = 1'b1;
      end
    endcase
    cb     = (phase != PH_CMD) || mid_cmd;
    status = pack_status(rqm, dio, ndma, cb, drv_busy);
  end
endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_pkg::*;
#(
  parameter int EXEC_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  input  logic [1:0] step_done,
  output logic       dma_req,
  input  logic       dma_ack,
  output logic       proto_err
);
  localparam int ECW = $clog2(EXEC_BYTES + 1);
  localparam int NDRV = 2;

  phase_e         phase;
  logic [3:0]     byte_idx;
  logic [4:0]     op_q;
  logic [7:0]     cmd_buf [CMD_MAX];
  logic [7:0]     res_buf [RES_MAX];
  logic [2:0]     res_idx, res_last;
  logic [ECW-1:0] exec_cnt;
  logic           gap, nd_mode, drv_q;

  logic           rqm, dio;
  logic [1:0]     drv_busy, drv_pend, trk_start, trk_clr;
  logic [7:0]     pcn [NDRV];

  // Named internal events
  logic       wr_ok, rd_ok, bad_access;
  logic [4:0] op_now;
  logic       cmd_last, seek_cmd, read_cmd, sense_cmd, implied;
  logic       byte_take, exec_done, res_done;
  logic [7:0] v1, v2, seek_tgt;
  logic       seek_drv, sense_any, sense_drv, read_drv;

  fdc_status_gen u_stat (
    .phase(phase), .mid_cmd(byte_idx != 4'd0), .gap(gap), .nd_mode(nd_mode),
    .drv_busy(drv_busy), .rqm(rqm), .dio(dio), .dma_req(dma_req), .status(status)
  );

  assign wr_ok      = wr_en && rqm && !dio;
  assign rd_ok      = rd_en && rqm && dio;
  assign bad_access = (wr_en && !wr_ok) || (rd_en && !rd_ok);

  assign op_now    = (byte_idx == 4'd0) ? wr_data[4:0] : op_q;
  assign cmd_last  = wr_ok && (byte_idx == cmd_len(op_now) - 4'd1);
  assign v1        = (byte_idx == 4'd1) ? wr_data : cmd_buf[1];
  assign v2        = (byte_idx == 4'd2) ? wr_data : cmd_buf[2];
  assign seek_cmd  = cmd_last && ((op_now == OP_SEEK) || (op_now == OP_RECAL));
  assign seek_drv  = v1[0];
  assign seek_tgt  = (op_now == OP_SEEK) ? v2 : 8'd0;
  assign read_cmd  = cmd_last && (op_now == OP_READ);
  assign read_drv  = cmd_buf[1][0];
  assign implied   = cmd_buf[2] != pcn[read_drv];
  assign sense_cmd = cmd_last && (op_now == OP_SENSE);
  assign sense_any = |drv_pend;
  assign sense_drv = !drv_pend[0];

  assign byte_take = (phase == PH_EXEC) && (nd_mode ? rd_ok : dma_ack);
  assign exec_done = byte_take && (exec_cnt == ECW'(EXEC_BYTES - 1));
  assign res_done  = (phase == PH_RES) && rd_ok && (res_idx == res_last);

  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    assign trk_start[g] = (seek_cmd && (seek_drv == 1'(g))) ||
                          (read_cmd && implied && (read_drv == 1'(g)));
    assign trk_clr[g]   = sense_cmd && sense_any && (sense_drv == 1'(g));
    fdc_drive_track #(.CW(8)) u_trk (
      .clk(clk), .rst(rst), .start(trk_start[g]), .explicit_seek(seek_cmd),
      .target(seek_cmd ? seek_tgt : cmd_buf[2]), .step_done(step_done[g]),
      .clr_pend(trk_clr[g]), .busy(drv_busy[g]), .pcn(pcn[g]),
      .pending(drv_pend[g])
    );
  end

  always_comb begin
    case (phase)
      PH_EXEC: rd_data = nd_mode ? 8'(exec_cnt) : 8'd0;
      PH_RES:  rd_data = res_buf[res_idx];
      default: rd_data = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CMD_MAX; i++) cmd_buf[i] <= 8'd0;
      for (int i = 0; i < RES_MAX; i++) res_buf[i] <= 8'd0;
    end else begin
      if (wr_ok) cmd_buf[byte_idx] <= wr_data;
      if (sense_cmd) begin
        res_buf[0] <= sense_any ? (ST0_SEEK_END | {7'd0, sense_drv}) : ST0_INVALID;
        res_buf[1] <= pcn[sense_drv];
      end else if (cmd_last && (cmd_len(op_now) == 4'd1)) begin
        res_buf[0] <= ST0_INVALID;
      end
      if (exec_done) begin
        res_buf[0] <= {7'd0, drv_q};
        res_buf[1] <= 8'd0;
        res_buf[2] <= 8'd0;
        for (int i = 3; i < RES_MAX; i++) res_buf[i] <= cmd_buf[i - 1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      byte_idx  <= 4'd0;
      op_q      <= 5'd0;
      res_idx   <= 3'd0;
      res_last  <= 3'd0;
      exec_cnt  <= '0;
      gap       <= 1'b0;
      nd_mode   <= 1'b0;
      drv_q     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      gap <= (phase == PH_EXEC) && nd_mode && rd_ok;
      if (bad_access) proto_err <= 1'b1;
      case (phase)
        PH_CMD: if (wr_ok) begin
          if (byte_idx == 4'd0) op_q <= wr_data[4:0];
          if (!cmd_last) begin
            byte_idx <= byte_idx + 4'd1;
          end else begin
            byte_idx <= 4'd0;
            case (op_now)
              OP_SPECIFY: nd_mode <= wr_data[0];
              OP_SEEK, OP_RECAL: ;
              OP_READ: begin
                drv_q    <= read_drv;
                exec_cnt <= '0;
                phase    <= implied ? PH_SEEK : PH_EXEC;
              end
              OP_SENSE: begin
                phase    <= PH_RES;
                res_idx  <= 3'd0;
                res_last <= sense_any ? 3'd1 : 3'd0;
              end
              default: begin
                phase    <= PH_RES;
                res_idx  <= 3'd0;
                res_last <= 3'd0;
              end
            endcase
          end
        end
        PH_SEEK: if (!drv_busy[drv_q]) phase <= PH_EXEC;
        PH_EXEC: if (byte_take) begin
          exec_cnt <= exec_cnt + 1'b1;
          if (exec_done) begin
            phase    <= PH_RES;
            res_idx  <= 3'd0;
            res_last <= 3'(RES_MAX - 1);
          end
        end
        default: if (rd_ok) begin
          if (res_done) phase <= PH_CMD;
          else          res_idx <= res_idx + 3'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] status,
  input logic [1:0] step_done,
  input logic       dma_req,
  input logic       proto_err,
  input logic       seek_cmd,
  input logic       res_done
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status[3:2] == 2'b00);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !status[4] |-> (status[7] && !status[6]));

  // R3
  res_end_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |=> (status[7:4] == 4'b1000));

  // R4
  seek_free_chk: assert property (@(posedge clk) disable iff (rst)
    seek_cmd |=> !status[4]);

  // R4
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status[0] && step_done[0] && !wr_en) |=> !status[0]);

  // R7
  ndma_phase_chk: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> (status[4] && status[6]));

  // R8
  dma_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (!status[7] && !status[5]));

  // R10
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(status[7] && !status[6])) |=> proto_err);

  // R10
  bad_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(status[7] && status[6])) |=> proto_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind fdc_phase_seq fdc_phase_seq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .status(status),
  .step_done(step_done), .dma_req(dma_req), .proto_err(proto_err),
  .seek_cmd(seek_cmd), .res_done(res_done)
);

// File: tb/fdc_phase_seq_bench.sv
module fdc_phase_seq_bench;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, dma_ack = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] step_done = 2'b00;
  logic [7:0] rd_data, status;
  logic       dma_req, proto_err;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [7:0] m_pcn  [2];
  logic       m_pend [2];
  logic [1:0] m_busy = 2'b00;

  always #4 clk = ~clk;

  fdc_phase_seq #(.EXEC_BYTES(NB)) u_fdc_phase_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .status(status), .step_done(step_done),
    .dma_req(dma_req), .dma_ack(dma_ack), .proto_err(proto_err)
  );

  function automatic logic [7:0] exp_stat(input int rqm, input int dio,
                                          input int nd, input int cb,
                                          input logic [1:0] bz);
    return 8'(rqm * 128 + dio * 64 + nd * 32 + cb * 16 + int'(bz));
  endfunction

  function automatic logic [7:0] exp_read_res(input int k, input logic drv,
                                              input logic [7:0] c, input logic [7:0] h,
                                              input logic [7:0] r, input logic [7:0] n);
    case (k)
      0: return {7'd0, drv};
      3: return c;
      4: return h;
      5: return r;
      6: return n;
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] b);
    while (!(status[7] && !status[6])) @(negedge clk);
    wr_data = b;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    while (!(status[7] && status[6])) @(negedge clk);
    b     = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_step(input int d);
    step_done[d] = 1'b1;
    @(negedge clk);
    step_done[d] = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_busy = 2'b00;
    for (int i = 0; i < 2; i++) begin
      m_pcn[i]  = 8'd0;
      m_pend[i] = 1'b0;
    end
  endtask

  task automatic do_seek(input logic drv, input logic [7:0] cyl, input bit recal);
    host_wr(recal ? 8'h07 : 8'h0F);
    chk("R3 busy after first byte", 32'(status[4]), 32'd1);
    host_wr({7'd0, drv});
    if (!recal) host_wr(cyl);
    m_busy[drv] = 1'b1;
    chk("R4 busy clear after last seek byte", 32'(status), 32'(exp_stat(1, 0, 0, 0, m_busy)));
  endtask

  task automatic do_step(input logic drv, input logic [7:0] cyl);
    pulse_step(int'(drv));
    m_busy[drv] = 1'b0;
    m_pcn[drv]  = cyl;
    m_pend[drv] = 1'b1;
    chk("R4 step_done clears drive busy", 32'(status), 32'(exp_stat(1, 0, 0, 0, m_busy)));
  endtask

  task automatic do_sense();
    logic [7:0] b;
    int d;
    host_wr(8'h08);
    chk("R3 busy during results", 32'(status[7:4]), 32'hD);
    if (m_pend[0] || m_pend[1]) begin
      d = m_pend[0] ? 0 : 1;
      host_rd(b);
      chk("R5 sense status byte", 32'(b), 32'(8'h20 + 8'(d)));
      host_rd(b);
      chk("R5 sense cylinder byte", 32'(b), 32'(m_pcn[d]));
      m_pend[d] = 1'b0;
    end else begin
      host_rd(b);
      chk("R5 sense with nothing pending", 32'(b), 32'h80);
    end
    chk("R3 busy clear after last result", 32'(status), 32'(exp_stat(1, 0, 0, 0, m_busy)));
  endtask

  task automatic do_read(input logic drv, input logic [7:0] c, input logic [7:0] h,
                         input logic [7:0] r, input logic [7:0] n, input bit polled);
    logic [7:0] b;
    bit imp;
    imp = (c != m_pcn[drv]);
    host_wr(8'hE6);          // upper bits ignored by decode (R3)
    host_wr({7'd0, drv});
    host_wr(c);
    host_wr(h);
    host_wr(r);
    host_wr(n);
    for (int i = 0; i < 3; i++) host_wr(8'h55);
    if (imp) begin
      chk("R6 implied seek status", 32'(status),
          32'(exp_stat(0, 0, 0, 1, m_busy | (2'b01 << drv))));
      pulse_step(int'(drv));
      m_pcn[drv] = c;
      @(negedge clk);
    end
    if (polled) begin
      chk("R7 polled execution status", 32'(status), 32'(exp_stat(1, 1, 1, 1, m_busy)));
      for (int i = 0; i < NB; i++) begin
        host_rd(b);
        chk("R7 execution byte value", 32'(b), 32'(i));
        if (i == 0)
          chk("R7 RQM gap after byte", 32'(status), 32'(exp_stat(0, 1, 1, 1, m_busy)));
      end
    end else begin
      chk("R8 DMA execution status", 32'(status), 32'(exp_stat(0, 0, 0, 1, m_busy)));
      chk("R8 dma_req high", 32'(dma_req), 32'd1);
      for (int i = 0; i < NB; i++) begin
        dma_ack = 1'b1;
        @(negedge clk);
      end
      dma_ack = 1'b0;
      chk("R8 dma_req drops after count", 32'(dma_req), 32'd0);
    end
    for (int k = 0; k < 7; k++) begin
      host_rd(b);
      chk("R9 read result byte", 32'(b), 32'(exp_read_res(k, drv, c, h, r, n)));
    end
    chk("R3 idle after read results", 32'(status), 32'(exp_stat(1, 0, 0, 0, m_busy)));
  endtask

  task automatic do_specify(input bit polled);
    host_wr(8'h03);
    host_wr(8'hAF);
    host_wr({7'd0, polled});
    chk("R11 specify leaves idle", 32'(status), 32'(exp_stat(1, 0, 0, 0, m_busy)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    chk("R1 reset status", 32'(status), 32'h80);
    chk("R1 reset proto_err", 32'(proto_err), 32'd0);
    chk("R1 reset dma_req", 32'(dma_req), 32'd0);

    // Reset selects DMA mode (R11, R8)
    do_read(1'b0, 8'd0, 8'd1, 8'd2, 8'd3, 1'b0);

    // Overlapped seeks on both drives (R4)
    do_seek(1'b0, 8'd5, 1'b0);
    do_seek(1'b1, 8'd9, 1'b0);
    chk("R2 both drive busy bits", 32'(status[1:0]), 32'd3);
    do_step(1'b1, 8'd9);
    do_step(1'b0, 8'd5);
    do_sense();   // drive 0 first
    do_sense();   // drive 1
    do_sense();   // nothing pending
    do_seek(1'b1, 8'd0, 1'b1);
    do_step(1'b1, 8'd0);
    do_sense();

    // Polled reads with and without implied seek (R6, R7, R9)
    do_specify(1'b1);
    do_read(1'b0, 8'd5, 8'd1, 8'd7, 8'd2, 1'b1);
    do_read(1'b1, 8'd33, 8'd0, 8'd4, 8'd1, 1'b1);

    // Invalid opcode (R11)
    host_wr(8'h1F);
    host_rd(b);
    chk("R11 invalid opcode result", 32'(b), 32'h80);
    chk("R11 idle after invalid", 32'(status), 32'h80);

    // Random seeks and sense
    for (int it = 0; it < 20; it++) begin
      logic d;
      logic [7:0] cy;
      d  = 1'($urandom % 2);
      cy = 8'($urandom % 256);
      do_seek(d, cy, 1'b0);
      do_step(d, cy);
      do_sense();
    end

    // Random reads, mixed modes
    for (int it = 0; it < 12; it++) begin
      logic d;
      logic [7:0] cy;
      bit pol;
      d   = 1'($urandom % 2);
      cy  = ($urandom % 2) ? m_pcn[d] : 8'($urandom % 256);
      pol = 1'($urandom % 2);
      do_specify(pol);
      do_read(d, cy, 8'($urandom), 8'($urandom), 8'($urandom), pol);
    end

    // Protocol errors (R10)
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 read in command phase flags error", 32'(proto_err), 32'd1);
    chk("R10 bad read ignored", 32'(status), 32'h80);
    host_wr(8'h08);
    wr_data = 8'h0F;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    chk("R10 write during results ignored", 32'(status[7:4]), 32'hD);
    host_rd(b);
    chk("R10 result intact after bad write", 32'(b), 32'h80);
    chk("R10 error stays set", 32'(proto_err), 32'd1);

    do_reset();
    chk("R1 reset clears error", 32'(proto_err), 32'd0);
    chk("R1 reset status again", 32'(status), 32'h80);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule